// File: doc/BRIEF.md
# Bidirectional Bus Shift Register

An eight-stage register placed between two bidirectional 8-bit buses, A and B. It copies a parallel word from one bus and presents it on the other, converts a serial bit stream into a parallel word on either bus, takes a parallel word from either bus for later serial shifting, or holds its contents by feeding each stage back to itself. A direction input picks which bus is the source and which the destination. An A-bus enable gates every use of bus A, both driving and sampling.

The block runs on one fast system clock. The register clock input is a slow, asynchronous strobe. It is synchronised and reduced to a one-cycle pulse on each rising edge. Parallel loads can follow that pulse (clocked mode) or happen on every system cycle (clock-independent mode, which models a transparent load). Serial shifting always follows the pulse. The last stage is brought out as a serial output so that a second register can be chained behind it. Each bus has a separate value output and a separate output enable, so the pad ring can build the tri-state drivers.

Top module: `bsr_bus_reg`

## Requirements
- R1: While rst_ni is low, both a_oe_o and b_oe_o are low. All stages read 0 after reset, so b_out_o = 0x00 and ser_o = 0.
- R2: With par_ser_i = 1 (parallel) and async_i = 0, the register loads the source bus on the third system clock edge after reg_clk_i rises. It does not load at any other time, and keeping reg_clk_i high does not cause a second load.
- R3: With par_ser_i = 1 and async_i = 1, the register loads the source bus on every system clock edge. Each bus change appears on the register one edge later, and reg_clk_i has no effect.
- R4: With a_to_b_i = 1, bus A is the source, b_oe_o = 1 and a_oe_o = 0. With a_to_b_i = 0, bus B is the source, b_oe_o = 0 and a_oe_o = a_en_i.
- R5: With a_en_i = 0, a_oe_o is low and a_in_i is never sampled.
- R6: In parallel mode with a_to_b_i = 1 and a_en_i = 0, every stage reloads its own value, so the contents are held whatever a_in_i and reg_clk_i do.
- R7: With par_ser_i = 0, each synchronised rising edge of reg_clk_i shifts the register by one place. The new contents are {q[6:0], ser_i}: ser_i enters bit 0 (stage 1) and data moves toward bit 7 (stage 8). async_i is ignored, and no shift happens without a reg_clk_i edge.
- R8: ser_o always equals bit 7 (stage 8) of the register.
- R9: a_oe_o and b_oe_o are never high in the same cycle. a_out_o and b_out_o both carry the register contents (bit k is stage k+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_clk_i | input | 1 | Asynchronous register clock strobe |
| par_ser_i | input | 1 | 1 = parallel load, 0 = serial shift |
| async_i | input | 1 | 1 = clock-independent parallel load |
| a_to_b_i | input | 1 | 1 = A is source, B is driven; 0 = reverse |
| a_en_i | input | 1 | Enables driving and sampling of bus A |
| ser_i | input | 1 | Serial data into stage 1 |
| a_in_i | input | 8 | Bus A sampled value |
| a_out_o | output | 8 | Bus A drive value |
| a_oe_o | output | 1 | Bus A output enable |
| b_in_i | input | 8 | Bus B sampled value |
| b_out_o | output | 8 | Bus B drive value |
| b_oe_o | output | 1 | Bus B output enable |
| ser_o | output | 1 | Stage 8, serial output for cascading |

## Verification
The register contents are visible on b_out_o in every cycle, so a wrongly loaded or shifted stage shows there on the cycle after the faulty edge. A synchroniser or edge detector with an off-by-one fault moves the load by one system cycle, which the bench detects by sampling just before and just after the third edge. A double pulse shows up as two shifts from a single strobe. A fault in the steering shows up either as a wrong source word, which gives a wrong value on b_out_o, or as an enable pattern that breaks the one-driver rule, which is visible on the oe outputs in the same cycle.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    LD_KEEP  = 2'd0,
    LD_PAR   = 2'd1,
    LD_SHIFT = 2'd2
  } ld_e;
endpackage

// File: rtl/bsr_edge_sync.sv
module bsr_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= async_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             tick_i,
  input  logic             par_ser_i,
  input  logic             async_i,
  input  logic             a_to_b_i,
  input  logic             a_en_i,
  input  logic [WIDTH-1:0] a_in_i,
  input  logic [WIDTH-1:0] b_in_i,
  input  logic [WIDTH-1:0] q_i,
  output ld_e              ld_o,
  output logic [WIDTH-1:0] par_d_o
);
  always_comb begin
    ld_o = LD_KEEP;
    if (par_ser_i) begin
      if (async_i || tick_i) ld_o = LD_PAR;
    end else if (tick_i) begin
      ld_o = LD_SHIFT;   // async select has no say in serial mode
    end
  end

  // disabled A side recirculates the stored word
  always_comb begin
    if (a_to_b_i) par_d_o = a_en_i ? a_in_i : q_i;
    else          par_d_o = b_in_i;
  end
endmodule

// File: rtl/bsr_stages.sv
module bsr_stages
  import bsr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ld_e              ld_i,
  input  logic [WIDTH-1:0] par_d_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;
  logic [WIDTH:0]   chain;

  assign chain = {q_q, ser_i};

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic d;
      always_comb begin
        unique case (ld_i)
          LD_PAR:   d = par_d_i[i];
          LD_SHIFT: d = chain[i];
          default:  d = q_q[i];
        endcase
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q[i] <= 1'b0;
        else         q_q[i] <= d;
      end
    end
  endgenerate

  assign q_o = q_q;
endmodule

// File: rtl/bsr_bus_reg.sv
module bsr_bus_reg
  import bsr_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_clk_i,
  input  logic             par_ser_i,
  input  logic             async_i,
  input  logic             a_to_b_i,
  input  logic             a_en_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] a_in_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_in_i,
  output logic [WIDTH-1:0] b_out_o,
  output logic             b_oe_o,
  output logic             ser_o
);
  logic             tick;
  ld_e              ld;
  logic [WIDTH-1:0] par_d;
  logic [WIDTH-1:0] q;
  logic             run_q;

  bsr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(reg_clk_i),
    .rise_o (tick)
  );

  bsr_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .tick_i   (tick),
    .par_ser_i(par_ser_i),
    .async_i  (async_i),
    .a_to_b_i (a_to_b_i),
    .a_en_i   (a_en_i),
    .a_in_i   (a_in_i),
    .b_in_i   (b_in_i),
    .q_i      (q),
    .ld_o     (ld),
    .par_d_o  (par_d)
  );

  bsr_stages #(.WIDTH(WIDTH)) u_stages (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld),
    .par_d_i(par_d),
    .ser_i  (ser_i),
    .q_o    (q)
  );

  // drivers stay off until the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign a_oe_o  = run_q & ~a_to_b_i & a_en_i;
  assign b_oe_o  = run_q & a_to_b_i;
  assign a_out_o = q;
  assign b_out_o = q;
  assign ser_o   = q[WIDTH-1];
endmodule

// File: rtl/bsr_bus_reg_chk.sv
module bsr_bus_reg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             par_ser_i,
  input logic             async_i,
  input logic             a_to_b_i,
  input logic             a_en_i,
  input logic [WIDTH-1:0] a_in_i,
  input logic [WIDTH-1:0] b_out_o,
  input logic             a_oe_o,
  input logic             b_oe_o,
  input logic             ser_o
);
  // R9
  no_dual_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));

  // R5
  a_en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_oe_o |-> a_en_i);

  // R6
  recirc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_ser_i && a_to_b_i && !a_en_i) |=> $stable(b_out_o));

  // R3
  async_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_ser_i && async_i && a_to_b_i && a_en_i) |=> (b_out_o == $past(a_in_i)));

  // R7
  serial_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_ser_i |=> ($stable(b_out_o) ||
                    (b_out_o[WIDTH-1:1] == $past(b_out_o[WIDTH-2:0]))));

  // R8
  ser_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_ser_i |=> ($stable(ser_o) || (ser_o == $past(b_out_o[WIDTH-2]))));
endmodule

bind bsr_bus_reg bsr_bus_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .par_ser_i(par_ser_i),
  .async_i  (async_i),
  .a_to_b_i (a_to_b_i),
  .a_en_i   (a_en_i),
  .a_in_i   (a_in_i),
  .b_out_o  (b_out_o),
  .a_oe_o   (a_oe_o),
  .b_oe_o   (b_oe_o),
  .ser_o    (ser_o)
);

// File: tb/tb_bsr_bus_reg.sv
module tb_bsr_bus_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         reg_clk = 1'b0, par_ser = 1'b1, async_s = 1'b0;
  logic         a_to_b = 1'b1, a_en = 1'b1, ser = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe, ser_out;

  int checks = 0, errors = 0;
  logic [W-1:0] exp_q;

  always #5 clk = ~clk;

  bsr_bus_reg #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_clk_i(reg_clk), .par_ser_i(par_ser),
    .async_i(async_s), .a_to_b_i(a_to_b), .a_en_i(a_en), .ser_i(ser),
    .a_in_i(a_in), .a_out_o(a_out), .a_oe_o(a_oe),
    .b_in_i(b_in), .b_out_o(b_out), .b_oe_o(b_oe), .ser_o(ser_out)
  );

  // fields: dir, a_en, a bus, b bus, expected word, expected a_oe, expected b_oe
  localparam int VN = 5;
  localparam logic [27:0] VEC [VN] = '{
    {1'b1, 1'b1, 8'h5A, 8'h00, 8'h5A, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'hEE, 8'hC3, 8'hC3, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'hFF, 8'h12, 8'hC3, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'h44, 8'h81, 8'h81, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h3C, 8'h99, 8'h3C, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) reg_clk = 1'b1;
    repeat (4) @(negedge clk);
    reg_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 drivers off during reset even with direction high
    chk("R1 oe in reset", {a_oe, b_oe}, 2'b00);
    chk("R1 word in reset", b_out, 8'h00);
    chk("R1 ser_o in reset", ser_out, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R4 b_oe after reset", {a_oe, b_oe}, 2'b01);

    // R2 R4 R5 R6 table walk, clocked parallel
    for (int i = 0; i < VN; i++) begin
      @(negedge clk);
      a_to_b = VEC[i][27]; a_en = VEC[i][26];
      a_in = VEC[i][25:18]; b_in = VEC[i][17:10];
      pulse();
      chk($sformatf("R2/R4/R6 vec%0d word", i), b_out, VEC[i][9:2]);
      chk($sformatf("R4/R5 vec%0d oe", i), {a_oe, b_oe}, VEC[i][1:0]);
      chk($sformatf("R9 vec%0d a_out", i), a_out, VEC[i][9:2]);
    end

    // R2 exact load timing and no reload while held high
    @(negedge clk) a_to_b = 1'b1; a_en = 1'b1; a_in = 8'hA7;
    repeat (5) @(negedge clk);
    chk("R2 no load without edge", b_out, 8'h3C);
    reg_clk = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 not before third edge", b_out, 8'h3C);
    @(negedge clk);
    chk("R2 load on third edge", b_out, 8'hA7);
    a_in = 8'h0F;
    repeat (6) @(negedge clk);
    chk("R2 level high no reload", b_out, 8'hA7);
    reg_clk = 1'b0;
    repeat (4) @(negedge clk);

    // R3 clock-independent load
    async_s = 1'b1; a_in = 8'h96;
    @(negedge clk);
    chk("R3 async load 1", b_out, 8'h96);
    a_in = 8'h11;
    @(negedge clk);
    chk("R3 async load 2", b_out, 8'h11);
    // R3 direction low loads from B
    a_to_b = 1'b0; b_in = 8'h6D;
    @(negedge clk);
    chk("R3 async from B", b_out, 8'h6D);
    // R6 R5 hold with A disabled, A bus ignored
    a_to_b = 1'b1; a_en = 1'b0; a_in = 8'h77;
    repeat (3) @(negedge clk);
    chk("R6 async recirc hold", b_out, 8'h6D);
    pulse();
    chk("R6 hold through strobe", b_out, 8'h6D);

    // R7 serial mode, async select ignored
    par_ser = 1'b0; a_en = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 no shift without edge", b_out, 8'h6D);
    exp_q = 8'h6D;
    for (int k = 0; k < 10; k++) begin
      ser = k[0] ^ k[2];
      pulse();
      exp_q = {exp_q[W-2:0], ser};
      chk($sformatf("R7 shift %0d", k), b_out, exp_q);
      chk($sformatf("R8 ser_o %0d", k), ser_out, exp_q[W-1]);
    end

    // R4 serial data on A when direction low and A enabled
    a_to_b = 1'b0; a_en = 1'b1; ser = 1'b1;
    pulse();
    exp_q = {exp_q[W-2:0], 1'b1};
    chk("R4 serial on A oe", {a_oe, b_oe}, 2'b10);
    chk("R4 serial on A word", a_out, exp_q);
    a_en = 1'b0;
    @(negedge clk);
    chk("R5 A disabled oe", {a_oe, b_oe}, 2'b00);

    // R1 reset mid-run
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 reset clears", {b_out, ser_out, a_oe, b_oe}, 11'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule